// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether a received frame is kept, judging only its 48-bit destination address. Frame parsing logic upstream presents the address with a one-cycle strobe. Seven cycles later the block reports three things: whether the frame is accepted, whether it is high priority, and a code that says which rule decided. A new address may be presented on every cycle, because the block is a pipeline with one stage per address byte. Each stage folds one byte into a CRC-32, and the last stage compares the address against the filter state.

Software sets up the filter through a write-only 32-bit port. The filter state is:
- sixteen exact-match slots, where slot 0 is the station's own unicast address and slots 1 to 15 are group addresses;
- a 512-bit acceptance hash table indexed by nine bits of the CRC;
- a second 512-bit table of the same layout that marks accepted addresses as high priority;
- three mode bits: accept everything, accept every group address, and accept the all-ones address.

Top module: `rx_dest_filter`

## Requirements
- R1: For each cycle with `da_valid` high, `res_valid` is high exactly 7 cycles later, and for no other cycle. Strobes on consecutive cycles each give their own result in order.
- R2: Slot s is written through three word addresses. Address 4*s+0 holds `da_addr[15:0]`, 4*s+1 holds `da_addr[31:16]` and 4*s+2 holds `da_addr[47:32]`, each taken from `cfg_wr_data[15:0]`. An address with `da_addr[40]`=0 is unicast. A unicast address is accepted with kind 2 only when it equals slot 0; slots 1 to 15 never match a unicast address.
- R3: A group address (`da_addr[40]`=1) that is not all ones and equals one of slots 1 to 15 is accepted with kind 3. This rule takes precedence over the hash rule and the all-group rule.
- R4: The hash index is bits 31:23 of a CRC-32 over the address, computed as follows. The polynomial is 0x04C11DB7, the register is preset to all ones and there is no final inversion. Bytes are taken from `da_addr[47:40]` down to `da_addr[7:0]`, and each byte is taken least significant bit first. Acceptance word 64+index[8:4] holds the table, and bit index[3:0] of that word is the entry. A group address that hits no slot but has its acceptance bit set is accepted with kind 5.
- R5: The priority table is at words 96+index[8:4], bit index[3:0]. `res_prio` is high only for an accepted address whose priority bit is set.
- R6: Control word 128 has three bits: bit 0 accept-everything, bit 1 all-group, bit 2 broadcast. With bit 0 set, an address that no other rule accepts is accepted with kind 1.
- R7: With bit 1 set, a group address that is not all ones and hits neither a slot nor the hash table is accepted with kind 6.
- R8: The all-ones address is accepted with kind 4 when bit 2 is set. With bit 2 clear it is rejected unless bit 0 is set. The slots, the hash table and the all-group rule never accept it.
- R9: A slot holding all zeros never matches, including the all-zero address.
- R10: After reset all slots, both tables and the control bits are zero, so every address is rejected. Writing zero to a register removes what it held, and the filter state changes only on writes.
- R11: Kind codes are 0 rejected, 1 accept-everything, 2 station, 3 group slot, 4 broadcast, 5 hash, 6 all-group. `res_accept` equals (kind != 0). While `res_valid` is low, `res_accept`, `res_prio` and `res_kind` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration word address |
| cfg_wr_data | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address present this cycle |
| da_addr | input | 48 | Destination address, first octet in bits 47:40 |
| res_valid | output | 1 | Decision present this cycle |
| res_accept | output | 1 | Frame accepted |
| res_prio | output | 1 | Accepted frame is high priority |
| res_kind | output | 3 | Rule that decided (R11 codes) |

## Verification
The hardest case to reach is a hash hit. Only an address whose CRC lands on a programmed bit produces one, and which bit that is cannot be seen at the ports. The bench therefore computes the CRC of a chosen group address itself, then sets exactly that acceptance bit and priority bit through the write port. It also checks that a second address falling elsewhere in the tables stays rejected. A burst of back-to-back strobes, mixing programmed and pseudo-random addresses, drives the pipeline with several addresses in flight at once.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_W     = 48;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic [2:0] {
        KIND_NONE    = 3'd0,
        KIND_PROMISC = 3'd1,
        KIND_STATION = 3'd2,
        KIND_GROUP   = 3'd3,
        KIND_BCAST   = 3'd4,
        KIND_HASH    = 3'd5,
        KIND_ALLGRP  = 3'd6
    } match_kind_e;

    // One pipeline lane: address travels with its partial CRC
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       crc;
    } lane_t;

    // Fold one byte into a non-reflected CRC-32, low bit of the byte first
    function automatic logic [31:0] crc_fold_byte(input logic [31:0] crc_in,
                                                  input logic [7:0]  data);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ data[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs #(
    parameter int NUM_SLOTS = 16,
    parameter int HASH_W    = 9,
    parameter int CFG_AW    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [CFG_AW-1:0]                wr_addr,
    input  logic [31:0]                      wr_data,
    output logic [NUM_SLOTS-1:0][47:0]       slot_o,
    output logic [(1<<HASH_W)-1:0]           acc_o,
    output logic [(1<<HASH_W)-1:0]           pri_o,
    output logic [2:0]                       ctrl_o
);
    localparam int HASH_BITS   = 1 << HASH_W;
    localparam int HWORDS      = HASH_BITS / 16;
    localparam int HW_IW       = $clog2(HWORDS);
    localparam int SLOT_IW     = $clog2(NUM_SLOTS);
    localparam int SLOT_REGION = NUM_SLOTS * 4;
    localparam int ACC_BASE    = SLOT_REGION;
    localparam int PRI_BASE    = ACC_BASE + HWORDS;
    localparam int CTRL_ADDR   = PRI_BASE + HWORDS;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][47:0] slot;
        logic [HASH_BITS-1:0]       acc;
        logic [HASH_BITS-1:0]       pri;
        logic [2:0]                 ctrl;
    } cfg_t;

    cfg_t              st_d, st_q;
    logic [CFG_AW-1:0] acc_off, pri_off;
    logic [SLOT_IW-1:0] sidx;
    logic [1:0]         half;
    logic               unused_hi;

    assign unused_hi = ^wr_data[31:16];
    assign acc_off   = wr_addr - CFG_AW'(ACC_BASE);
    assign pri_off   = wr_addr - CFG_AW'(PRI_BASE);
    assign sidx      = wr_addr[2 +: SLOT_IW];
    assign half      = wr_addr[1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr < CFG_AW'(SLOT_REGION)) begin
                if (half != 2'd3)
                    st_d.slot[sidx][{half, 4'b0} +: 16] = wr_data[15:0];
            end else if (wr_addr < CFG_AW'(PRI_BASE)) begin
                st_d.acc[{acc_off[HW_IW-1:0], 4'b0} +: 16] = wr_data[15:0];
            end else if (wr_addr < CFG_AW'(CTRL_ADDR)) begin
                st_d.pri[{pri_off[HW_IW-1:0], 4'b0} +: 16] = wr_data[15:0];
            end else if (wr_addr == CFG_AW'(CTRL_ADDR)) begin
                st_d.ctrl = wr_data[2:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o = st_q.slot;
    assign acc_o  = st_q.acc;
    assign pri_o  = st_q.pri;
    assign ctrl_o = st_q.ctrl;

    // R6: a control write lands on the mode bits at the next edge
    p_ctrl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CFG_AW'(CTRL_ADDR)) |=> (ctrl_o == $past(wr_data[2:0])));

    // R10: filter tables only move on a write
    p_tables_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(slot_o) && $stable(acc_o) && $stable(pri_o)));
endmodule

// File: rtl/rxf_crc_stage.sv
module rxf_crc_stage
    import rxf_pkg::*;
#(
    parameter int BYTE_IDX = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t in_i,
    output lane_t out_o
);
    localparam int MSB = ADDR_W - 1 - 8 * BYTE_IDX;

    lane_t st_d, st_q;

    always_comb begin
        st_d     = in_i;
        st_d.crc = crc_fold_byte(in_i.crc, in_i.addr[MSB -: 8]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q;

    // R1: every stage passes its strobe on after exactly one edge
    p_stage_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_i.valid |=> out_o.valid);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int HASH_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  lane_t                       in_i,
    input  logic [NUM_SLOTS-1:0][47:0]  slot_i,
    input  logic [(1<<HASH_W)-1:0]      acc_i,
    input  logic [(1<<HASH_W)-1:0]      pri_i,
    input  logic [2:0]                  ctrl_i,
    output logic                        valid_o,
    output logic                        accept_o,
    output logic                        prio_o,
    output logic [2:0]                  kind_o
);
    typedef struct packed {
        logic        valid;
        logic        accept;
        logic        prio;
        match_kind_e kind;
    } res_t;

    res_t                  res_d, res_q;
    logic [NUM_SLOTS-1:0]  hit;
    logic [HASH_W-1:0]     idx;
    logic                  grp, bcast, prom, allg, bc_en;
    match_kind_e           kind;
    logic                  unused_crc;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign hit[s] = (slot_i[s] == in_i.addr) && (|slot_i[s]);
    end

    assign idx        = in_i.crc[31 -: HASH_W];
    assign unused_crc = ^in_i.crc[31-HASH_W:0];
    assign grp        = in_i.addr[40];
    assign bcast      = &in_i.addr;
    assign prom       = ctrl_i[0];
    assign allg       = ctrl_i[1];
    assign bc_en      = ctrl_i[2];

    always_comb begin
        kind = KIND_NONE;
        if (!grp) begin
            if (hit[0])          kind = KIND_STATION;
            else if (prom)       kind = KIND_PROMISC;
        end else if (bcast) begin
            if (bc_en)           kind = KIND_BCAST;
            else if (prom)       kind = KIND_PROMISC;
        end else begin
            if (|hit[NUM_SLOTS-1:1]) kind = KIND_GROUP;
            else if (acc_i[idx]) kind = KIND_HASH;
            else if (allg)       kind = KIND_ALLGRP;
            else if (prom)       kind = KIND_PROMISC;
        end

        res_d = '0;
        if (in_i.valid) begin
            res_d.valid  = 1'b1;
            res_d.kind   = kind;
            res_d.accept = (kind != KIND_NONE);
            res_d.prio   = (kind != KIND_NONE) && pri_i[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_o  = res_q.valid;
    assign accept_o = res_q.accept;
    assign prio_o   = res_q.prio;
    assign kind_o   = res_q.kind;

    // R11: outputs are quiet between decisions
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!accept_o && !prio_o && kind_o == 3'd0));
    // R5: priority only rides on an accepted frame
    p_prio_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prio_o |-> accept_o);
    // R2: a unicast address never comes out with a group-only kind
    p_unicast_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i.valid && !in_i.addr[40]) |=> (kind_o inside {3'd0, 3'd1, 3'd2}));
    // R8: all-ones rejected when neither broadcast nor accept-everything is on
    p_bcast_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i.valid && (&in_i.addr) && !ctrl_i[2] && !ctrl_i[0]) |=> !accept_o);
    // R9: the zero address never matches a slot
    p_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i.valid && in_i.addr == '0 && !ctrl_i[0]) |=> !accept_o);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int HASH_W    = 9,
    parameter int CFG_AW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic              da_valid,
    input  logic [47:0]       da_addr,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_prio,
    output logic [2:0]        res_kind
);
    localparam int NUM_BYTES = ADDR_W / 8;
    localparam int HASH_BITS = 1 << HASH_W;

    logic [NUM_SLOTS-1:0][47:0] slot;
    logic [HASH_BITS-1:0]       acc, pri;
    logic [2:0]                 ctrl;
    lane_t                      lane [NUM_BYTES+1];

    rxf_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .HASH_W(HASH_W), .CFG_AW(CFG_AW)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .slot_o  (slot),
        .acc_o   (acc),
        .pri_o   (pri),
        .ctrl_o  (ctrl)
    );

    assign lane[0] = {da_valid, da_addr, 32'hFFFF_FFFF};

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        rxf_crc_stage #(.BYTE_IDX(b)) i_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (lane[b]),
            .out_o (lane[b+1])
        );
    end

    rxf_decide #(.NUM_SLOTS(NUM_SLOTS), .HASH_W(HASH_W)) i_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_i     (lane[NUM_BYTES]),
        .slot_i   (slot),
        .acc_i    (acc),
        .pri_i    (pri),
        .ctrl_i   (ctrl),
        .valid_o  (res_valid),
        .accept_o (res_accept),
        .prio_o   (res_prio),
        .kind_o   (res_kind)
    );

    // Edges seen since reset, saturating, so the latency checks look back only over live history
    logic [2:0] since_rst_d, since_rst_q;
    always_comb since_rst_d = (since_rst_q == 3'd7) ? since_rst_q : since_rst_q + 3'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst_q <= '0;
        else        since_rst_q <= since_rst_d;
    end

    // R1: strobe produces a decision exactly seven cycles on
    p_latency_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 3'd7 && $past(da_valid, 7)) |-> res_valid);
    // R1: no decision without a strobe seven cycles before
    p_latency_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 3'd7 && res_valid) |-> $past(da_valid, 7));
endmodule

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        res_valid, res_accept, res_prio;
    logic [2:0]  res_kind;

    always #4 clk = ~clk;

    rx_dest_filter i_rx_dest_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .da_valid(da_valid), .da_addr(da_addr),
        .res_valid(res_valid), .res_accept(res_accept), .res_prio(res_prio), .res_kind(res_kind)
    );

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Behavioural model of the filter state
    logic [47:0]  m_slot [16];
    logic [511:0] m_acc, m_pri;
    logic         m_prom, m_allg, m_bc;

    int         due_q[$];
    logic [5:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [31:0] m_crc(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int j = 0; j < 6; j++)
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ a[40 - 8*j + i];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        return c;
    endfunction

    function automatic int m_idx(input logic [47:0] a);
        logic [31:0] c;
        c = m_crc(a);
        return int'(c[31:23]);
    endfunction

    // Returns {valid, accept, prio, kind}
    function automatic logic [5:0] m_eval(input logic [47:0] a);
        int       idx;
        logic [2:0] k;
        bit       hit;
        idx = m_idx(a);
        k = 3'd0;
        hit = 1'b0;
        if (!a[40]) begin
            if (m_slot[0] == a && a != 48'h0) k = 3'd2;
            else if (m_prom) k = 3'd1;
        end else if (a == 48'hFFFF_FFFF_FFFF) begin
            if (m_bc) k = 3'd4;
            else if (m_prom) k = 3'd1;
        end else begin
            for (int s = 1; s < 16; s++)
                if (m_slot[s] == a && m_slot[s] != 48'h0) hit = 1'b1;
            if (hit) k = 3'd3;
            else if (m_acc[idx]) k = 3'd5;
            else if (m_allg) k = 3'd6;
            else if (m_prom) k = 3'd1;
        end
        return {1'b1, k != 3'd0, (k != 3'd0) && m_pri[idx], k};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: valid/accept/prio/kind got %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // Record expected results at the sampling edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && da_valid) begin
            due_q.push_back(cyc + 7);
            exp_q.push_back(m_eval(da_addr));
            tag_q.push_back(cur_tag);
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [5:0] act;
        if (!done) begin
            act = {res_valid, res_accept, res_prio, res_kind};
            if (!rst_n) begin
                check(act == 6'd0, "R10", act, 6'd0);
            end else if (due_q.size() > 0 && due_q[0] == cyc) begin
                check(act == exp_q[0], tag_q[0], act, exp_q[0]);
                void'(due_q.pop_front());
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end else begin
                check(act == 6'd0, "R11", act, 6'd0);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a[7:0]; cfg_wr_data = d;
        if (a < 64) begin
            if (a % 4 != 3) m_slot[a/4][(a%4)*16 +: 16] = d[15:0];
        end else if (a < 96) m_acc[(a-64)*16 +: 16] = d[15:0];
        else if (a < 128) m_pri[(a-96)*16 +: 16] = d[15:0];
        else if (a == 128) {m_bc, m_allg, m_prom} = d[2:0];
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_slot(input int s, input logic [47:0] a);
        wr(s*4 + 0, {16'h0, a[15:0]});
        wr(s*4 + 1, {16'h0, a[31:16]});
        wr(s*4 + 2, {16'h0, a[47:32]});
    endtask

    task automatic set_acc(input int idx);
        logic [15:0] w;
        w = m_acc[(idx/16)*16 +: 16];
        w[idx%16] = 1'b1;
        wr(64 + idx/16, {16'h0, w});
    endtask

    task automatic set_pri(input int idx);
        logic [15:0] w;
        w = m_pri[(idx/16)*16 +: 16];
        w[idx%16] = 1'b1;
        wr(96 + idx/16, {16'h0, w});
    endtask

    task automatic set_ctrl(input bit prom, input bit allg, input bit bc);
        wr(128, {29'h0, bc, allg, prom});
    endtask

    task automatic send(input logic [47:0] a, input string tag);
        @(negedge clk);
        da_valid = 1'b1; da_addr = a; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        da_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired at cycle %0d: got running expected finished", cyc);
        finish_run();
    end

    localparam logic [47:0] STN   = 48'h0211_2233_4455;
    localparam logic [47:0] GRP5  = 48'h0100_5E00_0007;
    localparam logic [47:0] UNI6  = 48'h00AA_BBCC_DDEE;
    localparam logic [47:0] HASHA = 48'h0100_5E12_3456;
    localparam logic [47:0] HASHB = 48'h0100_5E00_0099;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] OTHU  = 48'h0012_3456_789A;

    initial begin
        logic [63:0] rs;
        logic [47:0] pool [6];
        logic [47:0] a;
        for (int s = 0; s < 16; s++) m_slot[s] = '0;
        m_acc = '0; m_pri = '0; m_prom = 0; m_allg = 0; m_bc = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state rejects everything
        send(STN, "R10"); send(BCAST, "R10"); send(HASHA, "R10"); send(48'h0, "R10");
        idle(10);

        // R2: station slot, halfword order, near misses
        set_slot(0, STN);
        send(STN, "R2");
        send(STN ^ 48'h0000_0000_0001, "R2");
        send(STN ^ 48'h0000_0001_0000, "R2");
        send(STN ^ 48'h0004_0000_0000, "R2");
        idle(10);

        // R3 group slot; R2 unicast held in a group slot is ignored
        set_slot(5, GRP5);
        set_slot(6, UNI6);
        send(GRP5, "R3"); send(UNI6, "R2"); send(GRP5 ^ 48'h1, "R3");
        idle(10);

        // R4 hash acceptance, R5 priority
        set_acc(m_idx(HASHA));
        send(HASHA, "R4"); send(HASHB, "R4");
        idle(10);
        set_pri(m_idx(HASHA));
        set_pri(m_idx(OTHU));
        send(HASHA, "R5"); send(OTHU, "R5"); send(STN, "R5");
        idle(10);
        // R3 precedence over hash: group slot address with its hash bit set
        set_acc(m_idx(GRP5));
        send(GRP5, "R3");
        idle(10);

        // R7 all-group
        set_ctrl(0, 1, 0);
        send(48'h0300_0000_0042, "R7"); send(OTHU, "R7"); send(BCAST, "R8"); send(HASHA, "R7");
        idle(10);

        // R8 broadcast
        set_ctrl(0, 0, 1);
        send(BCAST, "R8");
        idle(10);

        // R6 accept-everything
        set_ctrl(1, 0, 0);
        send(OTHU, "R6"); send(BCAST, "R6"); send(48'h0700_0000_0001, "R6"); send(STN, "R6");
        idle(10);

        // R9 zero slot and zero address
        set_ctrl(0, 0, 0);
        set_slot(0, 48'h0);
        send(48'h0, "R9"); send(STN, "R9");
        idle(10);

        // R10 clearing by writing zero
        for (int w = 0; w < 32; w++) wr(64 + w, 32'h0);
        for (int w = 0; w < 32; w++) wr(96 + w, 32'h0);
        set_slot(5, 48'h0);
        send(HASHA, "R10"); send(GRP5, "R10");
        idle(10);

        // R1 back-to-back burst with mixed configuration
        set_slot(0, STN);
        set_slot(9, GRP5);
        set_acc(m_idx(HASHB));
        set_pri(m_idx(STN));
        set_ctrl(0, 0, 1);
        pool[0] = STN; pool[1] = GRP5; pool[2] = HASHB;
        pool[3] = BCAST; pool[4] = OTHU; pool[5] = HASHA;
        rs = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 30; k++) begin
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
            a = (k % 3 == 0) ? pool[k % 6] : rs[47:0];
            send(a, "R1");
        end
        idle(12);

        n_chk++;
        if (due_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 pending results got %0d expected 0", due_q.size());
        end
        finish_run();
    end
endmodule